// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the host side of a parallel NOR-style flash bus. It watches each accepted write cycle (address, data, write enable) and recognises the multi-cycle command sequences: a standard four-cycle program, entry into a persistent fast-program mode, the two-cycle program used inside that mode, the two-cycle exit from it, and the six-cycle chip erase and sector erase sequences. Each recognised sequence becomes a one-clock request pulse toward the array engine, with its address, data or sector number registered.

The engine that carries out the request raises a busy input. While busy is high every write is discarded and the decoder keeps its state. A write that does not fit the sequence under way drops the decoder back to array read without issuing anything. Inside the fast-program mode only the program and exit commands have any effect, and a mode flag shows that the mode is active.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all three request outputs are low and `bypass_mode` is low.
- R2: The writes AAh at key address 555h, 55h at key address 2AAh and A0h at 555h, followed by any fourth write, raise `prog_req` for exactly the one cycle after the fourth write. `prog_addr` and `prog_data` then hold that write's address and data. A fourth-cycle data value of F0h is programmed like any other value.
- R3: The writes AAh@555h, 55h@2AAh, 20h@555h set `bypass_mode` high in the cycle after the third write and issue no request.
- R4: With `bypass_mode` high, a write of A0h at any address followed by any write raises `prog_req` with that second write's address and data. `bypass_mode` stays high.
- R5: With `bypass_mode` high and no program or exit under way, a write whose data is neither A0h nor 90h issues no request and leaves the mode and the decoder state unchanged. This includes F0h and AAh.
- R6: With `bypass_mode` high, 90h then 00h at any addresses clear `bypass_mode`, and standard sequences are decoded again. 90h followed by any other value returns to the mode's idle state with `bypass_mode` still high.
- R7: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `chip_erase_req` for one cycle.
- R8: The same first five cycles followed by 30h at any address raise `sect_erase_req` for one cycle, with `sect_addr` equal to address bits [ADDR_W-1:SECT_LSB] of that last write.
- R9: Outside the fast-program mode, a write that does not match the next expected cycle returns the decoder to array read with no request. This includes F0h, and it holds even when the mismatching write is itself a valid first unlock cycle. The only exception is the program data cycle.
- R10: A write made while `busy` is high is ignored. No request results and the decoder state is held, so the sequence resumes once busy is low.
- R11: Key addresses are compared on the low KEY_W address bits only. Higher address bits are don't-care, and a mismatch in the low bits breaks the sequence.
- R12: At most one request output is high in any cycle, and no request stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write cycle strobe, one clock per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command codes sit in bits [7:0] |
| busy | input | 1 | Array engine busy; blocks all writes |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| sect_addr | output | ADDR_W-SECT_LSB | Sector to erase |
| bypass_mode | output | 1 | Fast-program mode active |

## Verification
The two events that can share a cycle are the write that completes a sequence and a high busy input. The bench raises busy on exactly the cycle of a final program or erase write, and on the exit pair inside the fast-program mode. It then expects no request and an unchanged mode flag. It then lowers busy and repeats only the final write. A request appearing at that point shows that the busy cycle neither fired the sequence nor aborted it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_FASTPGM  = 8'h20;
  localparam logic [7:0] CODE_SETUP    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_LEAVE_A  = 8'h90;
  localparam logic [7:0] CODE_LEAVE_B  = 8'h00;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UL1,
    ST_UL2,
    ST_PGM_DATA,
    ST_ERS_SETUP,
    ST_ERS_UL1,
    ST_ERS_UL2,
    ST_FP_IDLE,
    ST_FP_DATA,
    ST_FP_LEAVE
  } seq_state_t;

  // Classification of one write cycle, produced before the state machine.
  typedef struct packed {
    logic key1;      // address hits the first key
    logic unlock_a;  // AAh at first key
    logic unlock_b;  // 55h at second key
    logic c_prog;
    logic c_fast;
    logic c_setup;
    logic c_chip;
    logic c_sect;
    logic c_leave_a;
    logic c_leave_b;
  } cyc_class_t;

  // Address comparison restricted to a masked set of low bits.
  function automatic logic key_hit(input logic [31:0] addr,
                                   input logic [31:0] key,
                                   input logic [31:0] mask);
    return ((addr ^ key) & mask) == 32'h0;
  endfunction

  function automatic logic code_hit(input logic [7:0] d, input logic [7:0] c);
    return d == c;
  endfunction

  function automatic logic in_fast_mode(input seq_state_t s);
    return (s == ST_FP_IDLE) || (s == ST_FP_DATA) || (s == ST_FP_LEAVE);
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_W  = 11,
  parameter logic [31:0] KEY_A  = 32'h555,
  parameter logic [31:0] KEY_B  = 32'h2AA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output cyc_class_t        cls
);
  localparam logic [31:0] KEY_MASK = (32'h1 << KEY_W) - 32'h1;

  logic [31:0] addr_ext;
  logic [7:0]  code;
  logic        hit_a;
  logic        hit_b;

  assign addr_ext = 32'(addr);
  assign code     = data[7:0];
  assign hit_a    = key_hit(addr_ext, KEY_A, KEY_MASK);
  assign hit_b    = key_hit(addr_ext, KEY_B, KEY_MASK);

  always_comb begin
    cls           = '0;
    cls.key1      = hit_a;
    cls.unlock_a  = hit_a && code_hit(code, CODE_UNLOCK_A);
    cls.unlock_b  = hit_b && code_hit(code, CODE_UNLOCK_B);
    cls.c_prog    = code_hit(code, CODE_PROGRAM);
    cls.c_fast    = code_hit(code, CODE_FASTPGM);
    cls.c_setup   = code_hit(code, CODE_SETUP);
    cls.c_chip    = code_hit(code, CODE_CHIP);
    cls.c_sect    = code_hit(code, CODE_SECTOR);
    cls.c_leave_a = code_hit(code, CODE_LEAVE_A);
    cls.c_leave_b = code_hit(code, CODE_LEAVE_B);
  end
endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  cyc_class_t cls,
  output logic       fire_prog,
  output logic       fire_chip,
  output logic       fire_sect,
  output logic       in_fast
);
  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d   = state_q;
    fire_prog = 1'b0;
    fire_chip = 1'b0;
    fire_sect = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_READ:      state_d = cls.unlock_a ? ST_UL1 : ST_READ;
        ST_UL1:       state_d = cls.unlock_b ? ST_UL2 : ST_READ;
        ST_UL2: begin
          if (cls.key1 && cls.c_prog)       state_d = ST_PGM_DATA;
          else if (cls.key1 && cls.c_fast)  state_d = ST_FP_IDLE;
          else if (cls.key1 && cls.c_setup) state_d = ST_ERS_SETUP;
          else                              state_d = ST_READ;
        end
        ST_PGM_DATA: begin
          fire_prog = 1'b1;
          state_d   = ST_READ;
        end
        ST_ERS_SETUP: state_d = cls.unlock_a ? ST_ERS_UL1 : ST_READ;
        ST_ERS_UL1:   state_d = cls.unlock_b ? ST_ERS_UL2 : ST_READ;
        ST_ERS_UL2: begin
          fire_chip = cls.key1 && cls.c_chip;
          fire_sect = cls.c_sect;
          state_d   = ST_READ;
        end
        ST_FP_IDLE: begin
          if (cls.c_prog)         state_d = ST_FP_DATA;
          else if (cls.c_leave_a) state_d = ST_FP_LEAVE;
          else                    state_d = ST_FP_IDLE;
        end
        ST_FP_DATA: begin
          fire_prog = 1'b1;
          state_d   = ST_FP_IDLE;
        end
        ST_FP_LEAVE:  state_d = cls.c_leave_b ? ST_READ : ST_FP_IDLE;
        default:      state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READ;
    else        state_q <= state_d;
  end

  assign in_fast = in_fast_mode(state_q);
endmodule

// File: rtl/fcd_issue.sv
module fcd_issue #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SECT_LSB = 8,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_prog,
  input  logic              fire_chip,
  input  logic              fire_sect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_req,
  output logic              sect_erase_req,
  output logic [SECT_W-1:0] sect_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req       <= 1'b0;
      chip_erase_req <= 1'b0;
      sect_erase_req <= 1'b0;
    end else begin
      prog_req       <= fire_prog;
      chip_erase_req <= fire_chip;
      sect_erase_req <= fire_sect;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (fire_prog) begin
      prog_addr <= addr;
      prog_data <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sect_addr <= '0;
    else if (fire_sect) sect_addr <= addr[ADDR_W-1:SECT_LSB];
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned KEY_W    = 11,
  parameter int unsigned SECT_LSB = 8,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_req,
  output logic              sect_erase_req,
  output logic [SECT_W-1:0] sect_addr,
  output logic              bypass_mode
);
  cyc_class_t cyc_cls;
  logic       write_accept;
  logic       fire_prog;
  logic       fire_chip;
  logic       fire_sect;

  assign write_accept = wr_en && !busy;

  fcd_classify #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY_A(32'h555), .KEY_B(32'h2AA)
  ) u_classify (
    .addr (wr_addr),
    .data (wr_data),
    .cls  (cyc_cls)
  );

  fcd_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (write_accept),
    .cls       (cyc_cls),
    .fire_prog (fire_prog),
    .fire_chip (fire_chip),
    .fire_sect (fire_sect),
    .in_fast   (bypass_mode)
  );

  fcd_issue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
  ) u_issue (
    .clk            (clk),
    .rst_n          (rst_n),
    .fire_prog      (fire_prog),
    .fire_chip      (fire_chip),
    .fire_sect      (fire_sect),
    .addr           (wr_addr),
    .data           (wr_data),
    .prog_req       (prog_req),
    .prog_addr      (prog_addr),
    .prog_data      (prog_data),
    .chip_erase_req (chip_erase_req),
    .sect_erase_req (sect_erase_req),
    .sect_addr      (sect_addr)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SECT_LSB = 8,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              prog_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              chip_erase_req,
  input logic              sect_erase_req,
  input logic [SECT_W-1:0] sect_addr,
  input logic              bypass_mode
);
  logic any_req;
  assign any_req = prog_req || chip_erase_req || sect_erase_req;

  a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sect_erase_req}));

  a_r12_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  a_r10_busy_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> !any_req);

  a_r10_busy_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bypass_mode));

  a_r6_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bypass_mode));

  a_r2_prog_payload: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (prog_addr == $past(wr_addr)) && (prog_data == $past(wr_data)));

  a_r8_sector_field: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_req |-> sect_addr == $past(wr_addr[ADDR_W-1:SECT_LSB]));

  a_r7_erase_outside_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_req || sect_erase_req) |-> !bypass_mode);

  a_r3_entry_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_mode) |-> !any_req);

  a_r12_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $past(wr_en && !busy));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .prog_req(prog_req),
  .prog_addr(prog_addr), .prog_data(prog_data),
  .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
  .sect_addr(sect_addr), .bypass_mode(bypass_mode)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int SL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy = 1'b0;
  logic prog_req, chip_erase_req, sect_erase_req, bypass_mode;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [AW-SL-1:0] sect_addr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .KEY_W(11), .SECT_LSB(SL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
    .sect_addr(sect_addr), .bypass_mode(bypass_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the
  // write taken by the rising edge in between.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2:0] reqs();
    return {prog_req, chip_erase_req, sect_erase_req};
  endfunction

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic enter_fast();
    unlock();
    wr(12'h555, 8'h20);
  endtask

  task automatic leave_fast();
    wr(12'h000, 8'h90);
    wr(12'h000, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 requests", 32'(reqs()), 0);
    chk("R1 bypass_mode", 32'(bypass_mode), 0);

    // R2 standard program, then R12 single-cycle pulse
    unlock(); wr(12'h555, 8'hA0); wr(12'h7A3, 8'h5C);
    chk("R2 prog_req", 32'(reqs()), 3'b100);
    chk("R2 prog_addr", 32'(prog_addr), 32'h7A3);
    chk("R2 prog_data", 32'(prog_data), 32'h5C);
    @(negedge clk);
    chk("R12 pulse ends", 32'(reqs()), 0);

    // R2 program data F0h is data, not an abort
    unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'hF0);
    chk("R2 F0 as data", 32'(prog_req), 1);
    chk("R2 F0 data value", 32'(prog_data), 32'hF0);

    // R11 upper address bit don't-care; low-bit mismatch breaks
    wr(12'hD55, 8'hAA); wr(12'hAAA, 8'h55); wr(12'hD55, 8'hA0); wr(12'h011, 8'h3C);
    chk("R11 high bits ignored", 32'(prog_req), 1);
    wr(12'h554, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h77);
    chk("R11 low bit mismatch", 32'(reqs()), 0);

    // R3 / R9 sweep every third-cycle code
    for (int c = 0; c < 256; c++) begin
      unlock(); wr(12'h555, 8'(c));
      chk("R3 third cycle silent", 32'(reqs()), 0);
      chk("R3 mode after code", 32'(bypass_mode), 32'(c == 8'h20));
      wr(12'h123, 8'h10);
      chk("R9 follow-up prog", 32'(prog_req), 32'(c == 8'hA0));
      chk("R9 follow-up erase", 32'(reqs() & 3'b011), 0);
      if (c == 8'h20) begin
        chk("R5 mode kept", 32'(bypass_mode), 1);
        leave_fast();
        chk("R6 left", 32'(bypass_mode), 0);
      end
    end

    // R4 fast-mode program over all data values
    enter_fast();
    for (int d = 0; d < 256; d++) begin
      logic [AW-1:0] a;
      a = AW'((d * 37 + 5) % 4096);
      wr(AW'(d * 13), 8'hA0);
      chk("R4 first cycle silent", 32'(reqs()), 0);
      wr(a, 8'(d));
      chk("R4 prog_req", 32'(reqs()), 3'b100);
      chk("R4 prog_addr", 32'(prog_addr), 32'(a));
      chk("R4 prog_data", 32'(prog_data), 32'(d));
      chk("R4 mode stays", 32'(bypass_mode), 1);
    end

    // R5 every other first-cycle value is ignored in fast mode
    for (int d = 0; d < 256; d++) begin
      if (d != 8'hA0 && d != 8'h90) begin
        wr(12'h555, 8'(d));
        chk("R5 ignored no req", 32'(reqs()), 0);
        chk("R5 ignored mode", 32'(bypass_mode), 1);
      end
    end
    wr(12'h0F0, 8'hA0); wr(12'h0AB, 8'h66);
    chk("R5 state intact", 32'(prog_req), 1);

    // R6 false exit, then a real one
    wr(12'h000, 8'h90); wr(12'h000, 8'h12);
    chk("R6 false exit keeps mode", 32'(bypass_mode), 1);
    wr(12'h000, 8'hA0); wr(12'h044, 8'h21);
    chk("R6 back to fast idle", 32'(prog_req), 1);
    leave_fast();
    chk("R6 exit clears mode", 32'(bypass_mode), 0);
    wr(12'h777, 8'hA0); wr(12'h045, 8'h22);
    chk("R6 two-cycle program gone", 32'(reqs()), 0);

    // R7 / R8 sweep last erase code at two addresses
    for (int v = 0; v < 2; v++) begin
      for (int c = 0; c < 256; c++) begin
        logic [AW-1:0] a;
        logic [2:0] e;
        a = (v == 0) ? 12'h555 : 12'hC2B;
        e = {1'b0, (c == 8'h10 && v == 0), (c == 8'h30)};
        unlock(); wr(12'h555, 8'h80); unlock();
        chk("R7 no early request", 32'(reqs()), 0);
        wr(a, 8'(c));
        chk("R7 R8 erase request", 32'(reqs()), 32'(e));
        if (c == 8'h30) chk("R8 sector field", 32'(sect_addr), 32'(a[AW-1:SL]));
      end
    end

    // R9 abort by F0h and by a restart in mid sequence
    unlock(); wr(12'h555, 8'hF0); wr(12'h555, 8'hA0); wr(12'h000, 8'h11);
    chk("R9 F0 aborts", 32'(reqs()), 0);
    wr(12'h555, 8'hAA); wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    wr(12'h000, 8'h11);
    chk("R9 mismatch returns to read", 32'(reqs()), 0);

    // R10 busy holds state mid sequence
    wr(12'h555, 8'hAA);
    busy = 1'b1; wr(12'h2AA, 8'h55); wr(12'h555, 8'hF0); busy = 1'b0;
    wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h456, 8'h99);
    chk("R10 resumed after busy", 32'(prog_req), 1);
    // R10 busy on the completing write
    unlock(); wr(12'h555, 8'hA0);
    busy = 1'b1; wr(12'h456, 8'h99);
    chk("R10 busy blocks final write", 32'(reqs()), 0);
    busy = 1'b0; wr(12'h456, 8'h98);
    chk("R10 final write after busy", 32'(prog_req), 1);
    chk("R10 data after busy", 32'(prog_data), 32'h98);
    unlock(); wr(12'h555, 8'h80); unlock();
    busy = 1'b1; wr(12'h555, 8'h10);
    chk("R10 busy blocks chip erase", 32'(reqs()), 0);
    busy = 1'b0; wr(12'h555, 8'h10);
    chk("R10 chip erase after busy", 32'(reqs()), 3'b010);
    // R10 busy during fast-mode exit
    enter_fast();
    busy = 1'b1; leave_fast(); busy = 1'b0;
    chk("R10 exit blocked", 32'(bypass_mode), 1);
    leave_fast();
    chk("R10 exit after busy", 32'(bypass_mode), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule